// File: doc/BRIEF.md
# Serial Receive Line Status Flags

This unit sits beside the receive path of a UART-style serial port and keeps three sticky status flags about the receive line. The first records an active edge on the line, with the edge direction chosen by a receive-polarity input. The second records a bit error: while the port transmits, the received level is compared with the bit being sent, and the received level seen at the mismatch is kept in a separate value bit. The third records a break, meaning the line has stayed at its space level for a long run of bit-sample strobes.

Software reads the flags through an 8-bit register on a simple read/write bus and clears each flag by writing 1 to it. The bus only reaches this register while the alternate-map select is high. Each flag is ANDed with an enable input to drive its interrupt output.

The receive input passes through a two-flop synchronizer. The polarity input gives the logical level used by the bit-error and break logic as `logical = synchronized rx XOR rx_pol_i`. The space (break) level is logical 0.

Top module: `line_status_flags`

## Requirements
- R1: After reset the register reads 0x00 and all three interrupt outputs are low.
- R2: Bit 7 (edge flag) sets on a falling edge of `rx_i` when `rx_pol_i` is 0, and on a rising edge when it is 1. An edge in the other direction leaves it unchanged.
- R3: Bit 1 (bit-error flag) sets on a `smp_stb_i` cycle only when `berr_en_i` is 1 and the logical receive level differs from `tx_bit_i`. A matching level, or detection disabled, leaves it unchanged.
- R4: Bit 2 (bit-error value) takes the logical receive level on the strobe that sets bit 1: 1 means high was seen where low was sent, and 0 means low was seen where high was sent. It keeps its value on all other cycles, including matching strobes and a clear of bit 1.
- R5: Bit 0 (break flag) sets when `brk_en_i` is 1 and the logical level has been 0 for BRK_LEN consecutive strobes (default 10). Nine strobes are not enough, and nothing sets while `brk_en_i` is 0.
- R6: A break is reported once. Further space strobes do not set bit 0 again until the line has returned to logical 1. After that, a new run of BRK_LEN space strobes reports a new break.
- R7: Writing 1 to bit 7, 1 or 0 clears that flag, and writing 0 leaves it unchanged. When a hardware set and a write-1 clear reach the same flag in the same cycle, the flag ends up set.
- R8: While `alt_map_i` is 0, `reg_rdata_o` reads 0 and writes have no effect.
- R9: Bits 6 to 3 always read 0. Bit 2 cannot be written.
- R10: Each interrupt output is high exactly when its flag is set and its enable input is 1. The outputs are `edge_irq_o`, `berr_irq_o` and `brk_irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Asynchronous receive line |
| rx_pol_i | input | 1 | Receive polarity: 0 normal, 1 inverted |
| smp_stb_i | input | 1 | Bit-sample strobe, one cycle per bit |
| tx_bit_i | input | 1 | Logical bit currently transmitted |
| berr_en_i | input | 1 | Bit-error detection enable |
| brk_en_i | input | 1 | Break detection enable |
| edge_ie_i | input | 1 | Edge interrupt enable |
| berr_ie_i | input | 1 | Bit-error interrupt enable |
| brk_ie_i | input | 1 | Break interrupt enable |
| alt_map_i | input | 1 | Alternate-map select gating register access |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Write data, 1 clears a flag |
| reg_rdata_o | output | 8 | Read data |
| edge_irq_o | output | 1 | Edge interrupt |
| berr_irq_o | output | 1 | Bit-error interrupt |
| brk_irq_o | output | 1 | Break interrupt |

## Verification
The assertions assume that `smp_stb_i` is a single-cycle pulse and that `rx_i`, `tx_bit_i` and `rx_pol_i` do not change within the three cycles before a strobe, so the synchronized level is settled when it is sampled. The stimulus changes the receive line and then waits four cycles before any strobe or read. It changes polarity only while the line is quiet and no strobes are issued. It raises `smp_stb_i` for exactly one cycle each time. The set-versus-clear case is the only stimulus that drives a strobe and a write in the same cycle.

// File: rtl/lsf_pkg.sv
package lsf_pkg;
  localparam int REG_W    = 8;
  localparam int EDGE_BIT = 7;
  localparam int BVAL_BIT = 2;
  localparam int BERR_BIT = 1;
  localparam int BRK_BIT  = 0;

  typedef struct packed {
    logic edge_f;
    logic berr_f;
    logic berr_v;
    logic brk_f;
  } lsf_flags_t;
endpackage

// File: rtl/lsf_rx_sync.sv
module lsf_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  input  logic rx_pol_i,
  output logic lvl_o,
  output logic edge_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[g] <= 1'b1;
        else         chain_q[g] <= rx_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[g] <= 1'b1;
        else         chain_q[g] <= chain_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= chain_q[STAGES-1];

  // physical edge compare: polarity changes never fake an edge
  assign edge_o = rx_pol_i ? (~prev_q & chain_q[STAGES-1])
                           : (prev_q & ~chain_q[STAGES-1]);
  assign lvl_o  = chain_q[STAGES-1] ^ rx_pol_i;
endmodule

// File: rtl/lsf_berr_mon.sv
module lsf_berr_mon (
  input  logic stb_i,
  input  logic en_i,
  input  logic lvl_i,
  input  logic tx_bit_i,
  output logic set_o,
  output logic val_o
);
  assign set_o = stb_i & en_i & (lvl_i ^ tx_bit_i);
  assign val_o = lvl_i;
endmodule

// File: rtl/lsf_brk_det.sv
module lsf_brk_det #(
  parameter int BRK_LEN = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic lvl_i,
  output logic pulse_o
);
  localparam int CNT_W = $clog2(BRK_LEN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BRK_LEN - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BRK_LEN);

  logic [CNT_W-1:0] cnt_q;

  // counter saturates at FULL, so one report per break until line idles
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                          cnt_q <= '0;
    else if (lvl_i)                       cnt_q <= '0;
    else if (stb_i && cnt_q != FULL)      cnt_q <= cnt_q + 1'b1;

  assign pulse_o = stb_i & ~lvl_i & (cnt_q == LAST);

  // R6
  once_per_break_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/line_status_flags.sv
module line_status_flags
  import lsf_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BRK_LEN     = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_i,
  input  logic             rx_pol_i,
  input  logic             smp_stb_i,
  input  logic             tx_bit_i,
  input  logic             berr_en_i,
  input  logic             brk_en_i,
  input  logic             edge_ie_i,
  input  logic             berr_ie_i,
  input  logic             brk_ie_i,
  input  logic             alt_map_i,
  input  logic             reg_rd_i,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             edge_irq_o,
  output logic             berr_irq_o,
  output logic             brk_irq_o
);
  logic lvl, edge_set, berr_set, berr_val, brk_pulse, brk_set;
  logic wr_en;
  logic [REG_W-1:0] clr;
  lsf_flags_t flg_q, flg_d;
  logic [REG_W-1:0] reg_view;

  lsf_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .rx_i, .rx_pol_i, .lvl_o(lvl), .edge_o(edge_set)
  );

  lsf_berr_mon u_berr (
    .stb_i(smp_stb_i), .en_i(berr_en_i), .lvl_i(lvl), .tx_bit_i,
    .set_o(berr_set), .val_o(berr_val)
  );

  lsf_brk_det #(.BRK_LEN(BRK_LEN)) u_brk (
    .clk_i, .rst_ni, .stb_i(smp_stb_i), .lvl_i(lvl), .pulse_o(brk_pulse)
  );

  assign brk_set = brk_pulse & brk_en_i;
  assign wr_en   = reg_wr_i & alt_map_i;
  assign clr     = wr_en ? reg_wdata_i : '0;

  // set beats a same-cycle write-1 clear
  always_comb begin
    flg_d.edge_f = edge_set | (flg_q.edge_f & ~clr[EDGE_BIT]);
    flg_d.berr_f = berr_set | (flg_q.berr_f & ~clr[BERR_BIT]);
    flg_d.brk_f  = brk_set  | (flg_q.brk_f  & ~clr[BRK_BIT]);
    flg_d.berr_v = berr_set ? berr_val : flg_q.berr_v;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) flg_q <= '0;
    else         flg_q <= flg_d;

  always_comb begin
    reg_view           = '0;
    reg_view[EDGE_BIT] = flg_q.edge_f;
    reg_view[BVAL_BIT] = flg_q.berr_v;
    reg_view[BERR_BIT] = flg_q.berr_f;
    reg_view[BRK_BIT]  = flg_q.brk_f;
  end

  assign reg_rdata_o = (reg_rd_i && alt_map_i) ? reg_view : '0;
  assign edge_irq_o  = flg_q.edge_f & edge_ie_i;
  assign berr_irq_o  = flg_q.berr_f & berr_ie_i;
  assign brk_irq_o   = flg_q.brk_f  & brk_ie_i;

  // R2
  edge_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_set |=> flg_q.edge_f);
  // R3
  berr_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flg_q.berr_f) |-> $past(berr_en_i && smp_stb_i));
  // R5
  brk_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flg_q.brk_f) |-> $past(brk_en_i));
  // R7
  edge_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!edge_set && !(wr_en && reg_wdata_i[EDGE_BIT])) |=> $stable(flg_q.edge_f));
  // R8
  rd_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alt_map_i |-> reg_rdata_o == '0);
  // R8
  wr_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alt_map_i && !berr_set) |=> $stable(flg_q.berr_f));
endmodule

// File: tb/line_status_flags_tb_top.sv
module line_status_flags_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1, pol = 1'b0, stb = 1'b0, tx_bit = 1'b0;
  logic berr_en = 1'b0, brk_en = 1'b0;
  logic edge_ie = 1'b0, berr_ie = 1'b0, brk_ie = 1'b0;
  logic alt = 1'b1, rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic edge_irq, berr_irq, brk_irq;
  logic irq_req = 1'b0;
  int checks = 0, fails = 0;

  typedef struct {
    bit         kind;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  line_status_flags dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .rx_pol_i(pol), .smp_stb_i(stb),
    .tx_bit_i(tx_bit), .berr_en_i(berr_en), .brk_en_i(brk_en),
    .edge_ie_i(edge_ie), .berr_ie_i(berr_ie), .brk_ie_i(brk_ie),
    .alt_map_i(alt), .reg_rd_i(rd), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .edge_irq_o(edge_irq), .berr_irq_o(berr_irq),
    .brk_irq_o(brk_irq)
  );

  // monitor: pop and compare away from the active edge
  always @(negedge clk) begin
    if (rd || irq_req) begin
      item_t it;
      logic [7:0] act;
      checks++;
      if (sb_q.size() == 0) begin
        fails++;
        $display("FAIL scoreboard empty");
      end else begin
        it  = sb_q.pop_front();
        act = it.kind ? {5'b0, edge_irq, berr_irq, brk_irq} : rdata;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask
  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) tick();
  endtask
  task automatic chk_rd(logic [7:0] e, string tag);
    item_t it; it.kind = 1'b0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    rd = 1'b1; tick(); rd = 1'b0;
  endtask
  task automatic chk_irq(logic [2:0] e, string tag);
    item_t it; it.kind = 1'b1; it.exp = {5'b0, e}; it.tag = tag;
    sb_q.push_back(it);
    irq_req = 1'b1; tick(); irq_req = 1'b0;
  endtask
  task automatic reg_write(logic [7:0] d);
    wr = 1'b1; wdata = d; tick(); wr = 1'b0; wdata = '0;
  endtask
  task automatic strobe(int n);
    for (int i = 0; i < n; i++) begin
      stb = 1'b1; tick(); stb = 1'b0; tick();
    end
  endtask
  task automatic set_rx(logic v);
    rx = v; wait_n(4);
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    chk_rd(8'h00, "R1 reset value");
    chk_irq(3'b000, "R1 irqs low");

    // edges, polarity 0
    set_rx(1'b0);
    chk_rd(8'h80, "R2 falling pol0");
    edge_ie = 1'b1;
    chk_irq(3'b100, "R10 edge irq");
    reg_write(8'h80);
    chk_rd(8'h00, "R7 clear edge");
    chk_irq(3'b000, "R10 edge irq off");
    set_rx(1'b1);
    chk_rd(8'h00, "R2 rising ignored pol0");

    // polarity 1
    pol = 1'b1; tick();
    set_rx(1'b0);
    chk_rd(8'h00, "R2 falling ignored pol1");
    set_rx(1'b1);
    chk_rd(8'h80, "R2 rising pol1");
    reg_write(8'h7F);
    chk_rd(8'h80, "R7 write zero keeps flag");
    reg_write(8'hFF);
    chk_rd(8'h00, "R7 clear all");
    pol = 1'b0; edge_ie = 1'b0; tick();

    // bit error
    tx_bit = 1'b0;
    strobe(1);
    chk_rd(8'h00, "R3 detection disabled");
    berr_en = 1'b1;
    strobe(1);
    chk_rd(8'h06, "R3 R4 high seen low sent");
    berr_ie = 1'b1;
    chk_irq(3'b010, "R10 berr irq");
    berr_ie = 1'b0;
    chk_irq(3'b000, "R10 berr enable low");
    reg_write(8'h02);
    chk_rd(8'h04, "R4 value kept after clear");
    tx_bit = 1'b1;
    strobe(1);
    chk_rd(8'h04, "R3 R4 match no set");
    set_rx(1'b0);
    strobe(1);
    chk_rd(8'h82, "R4 low seen high sent");
    reg_write(8'hFF);
    berr_en = 1'b0;
    set_rx(1'b1);

    // break
    brk_en = 1'b1;
    set_rx(1'b0);
    reg_write(8'h80);
    strobe(9);
    chk_rd(8'h00, "R5 nine strobes not enough");
    strobe(1);
    chk_rd(8'h01, "R5 break after ten");
    brk_ie = 1'b1;
    chk_irq(3'b001, "R10 brk irq");
    brk_ie = 1'b0;
    reg_write(8'h01);
    strobe(5);
    chk_rd(8'h00, "R6 reported once");
    set_rx(1'b1);
    set_rx(1'b0);
    reg_write(8'h80);
    strobe(10);
    chk_rd(8'h01, "R6 rearm after idle");
    reg_write(8'hFF);
    brk_en = 1'b0;
    set_rx(1'b1);
    set_rx(1'b0);
    reg_write(8'h80);
    strobe(10);
    chk_rd(8'h00, "R5 break disabled");
    set_rx(1'b1);

    // set wins over clear
    berr_en = 1'b1; tx_bit = 1'b0;
    strobe(1);
    stb = 1'b1; wr = 1'b1; wdata = 8'h02; tick();
    stb = 1'b0; wr = 1'b0; wdata = '0; tick();
    chk_rd(8'h06, "R7 set wins over clear");
    berr_en = 1'b0;

    // alternate map gating
    alt = 1'b0;
    chk_rd(8'h00, "R8 read gated");
    reg_write(8'hFF);
    alt = 1'b1;
    chk_rd(8'h06, "R8 write ignored");
    reg_write(8'h7C);
    chk_rd(8'h06, "R9 reserved and value bit not writable");

    wait_n(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule